// File: doc/BRIEF.md
# Pad Interrupt Source Router

This block takes a wide bank of pad input lines and steers one of them onto each of a small number of interrupt channels. Every channel owns an 8-bit source field that names the pad it listens to. Each pad is first passed through a two-flop synchronizer, then multiplexed, and the result leaves the block through a registered per-channel output.

Alongside the routed signal, each channel also presents its own trigger settings to a trigger conditioner further down the chain. There are three enables per channel: single edge, both edges and active-low polarity. There is also a 4-bit filter code per channel. All of this state sits in four 32-bit registers behind a simple word bus with address, write enable, write data and registered read data. Software changes these registers by read-modify-write, so each register returns exactly the last value written to it.

Top module: `irq_pad_router`

## Requirements
- R1: While reset is high, and in the cycle after, every register reads as zero and every channel output is zero. This routes all channels to pad 0 with all trigger enables clear.
- R2: A read of offset 0x00, 0x04, 0x08 or 0x0C returns all 32 bits last written there, including bits that no channel decodes.
- R3: A read of any other byte address returns zero. A write to any other byte address changes no register and no output.
- R4: The source for channel c (c = 0..3) is bits [(c mod 4)*8 +: 8] of offset 0x04. For c = 4..7 it is the same field position in offset 0x08. ch_raw[c] shows the synchronized level of that pad.
- R5: A source value at or above NUM_PADS (120 by default, so 120..255) forces ch_raw[c] to 0. Value 119 still routes pad 119.
- R6: In offset 0x00, channel c's single-edge enable is bit c, its both-edges enable is bit 8+c and its active-low bit is bit 16+c. These appear on ch_sgl_en[c], ch_both_en[c] and ch_low_pol[c].
- R7: In offset 0x0C, channel c's filter code is bits [c*4 +: 4], and it appears on ch_filt_sel[c*4 +: 4].
- R8: A pad change that is driven before clock edge k appears on ch_raw at edge k+2, and not earlier. The path is two synchronizer stages plus the output register.
- R9: A register written at edge k changes the configuration outputs at edge k+1. Read data for an address presented before edge k is valid after edge k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | NUM_PADS | Asynchronous pad levels |
| reg_addr | input | 8 | Byte address of the register access |
| reg_we | input | 1 | Write strobe, one word per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ch_raw | output | NUM_CH | Routed synchronized pad level per channel |
| ch_sgl_en | output | NUM_CH | Single-edge enable per channel |
| ch_both_en | output | NUM_CH | Both-edges enable per channel |
| ch_low_pol | output | NUM_CH | Active-low polarity per channel |
| ch_filt_sel | output | NUM_CH*4 | Filter code per channel |

## Verification
Each result in this block has a fixed latency, and every check is timed to match it.
- Read data lands on the edge that samples the address.
- Configuration outputs move one edge after the write edge.
- Routed pad levels move three edges after the pad is driven.

The bench drives and samples on the falling edge. It checks each output at the first falling edge where the new value is due. Where a requirement states a latency, it also checks one falling edge earlier, to confirm the old value still holds there.

// File: rtl/irq_pad_router_pkg.sv
package irq_pad_router_pkg;
  localparam int ADDR_W        = 8;
  localparam int REG_W         = 32;
  localparam int LANE_W        = 8;
  localparam int LANES_PER_REG = REG_W / LANE_W;
  localparam int FILT_W        = 4;
  localparam int SGL_BASE      = 0;
  localparam int BOTH_BASE     = 8;
  localparam int LOW_BASE      = 16;

  localparam logic [ADDR_W-1:0] OFS_TRIG  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_PADLO = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_PADHI = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_FILT  = 8'h0C;

  typedef enum logic [2:0] {
    RSEL_TRIG,
    RSEL_PADLO,
    RSEL_PADHI,
    RSEL_FILT,
    RSEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e r;
    case (a)
      OFS_TRIG:  r = RSEL_TRIG;
      OFS_PADLO: r = RSEL_PADLO;
      OFS_PADHI: r = RSEL_PADHI;
      OFS_FILT:  r = RSEL_FILT;
      default:   r = RSEL_NONE;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/irq_pad_regs.sv
module irq_pad_regs
  import irq_pad_router_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [REG_W-1:0]  trig_q,
  output logic [REG_W-1:0]  padlo_q,
  output logic [REG_W-1:0]  padhi_q,
  output logic [REG_W-1:0]  filt_q
);
  reg_sel_e sel;

  always_comb sel = decode_addr(addr);

  // Storage: full width kept so read-modify-write returns every bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q  <= '0;
      padlo_q <= '0;
      padhi_q <= '0;
      filt_q  <= '0;
    end else if (we) begin
      case (sel)
        RSEL_TRIG:  trig_q  <= wdata;
        RSEL_PADLO: padlo_q <= wdata;
        RSEL_PADHI: padhi_q <= wdata;
        RSEL_FILT:  filt_q  <= wdata;
        default:    ;
      endcase
    end
  end

  // Registered read port; holes read as zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (sel)
        RSEL_TRIG:  rdata <= trig_q;
        RSEL_PADLO: rdata <= padlo_q;
        RSEL_PADHI: rdata <= padhi_q;
        RSEL_FILT:  rdata <= filt_q;
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_pad_sync.sv
module irq_pad_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/irq_chan_slice.sv
module irq_chan_slice #(
  parameter int NUM_PADS = 120,
  parameter int SEL_W    = 8,
  parameter int FILT_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PADS-1:0] pads,
  input  logic [SEL_W-1:0]    sel,
  input  logic                sgl_in,
  input  logic                both_in,
  input  logic                low_in,
  input  logic [FILT_W-1:0]   filt_in,
  output logic                raw_o,
  output logic                sgl_o,
  output logic                both_o,
  output logic                low_o,
  output logic [FILT_W-1:0]   filt_o
);
  localparam int SPAN = 1 << SEL_W;

  // Zero-extend the pad bank to the full select span so that any
  // select at or past NUM_PADS lands on a constant zero.
  logic [SPAN-1:0] ext;
  always_comb begin
    ext = '0;
    ext[NUM_PADS-1:0] = pads;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_o  <= 1'b0;
      sgl_o  <= 1'b0;
      both_o <= 1'b0;
      low_o  <= 1'b0;
      filt_o <= '0;
    end else begin
      raw_o  <= ext[sel];
      sgl_o  <= sgl_in;
      both_o <= both_in;
      low_o  <= low_in;
      filt_o <= filt_in;
    end
  end
endmodule

// File: rtl/irq_pad_router.sv
module irq_pad_router
  import irq_pad_router_pkg::*;
#(
  parameter int NUM_PADS    = 120,
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_PADS-1:0]      pad_in,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic                     reg_we,
  input  logic [REG_W-1:0]         reg_wdata,
  output logic [REG_W-1:0]         reg_rdata,
  output logic [NUM_CH-1:0]        ch_raw,
  output logic [NUM_CH-1:0]        ch_sgl_en,
  output logic [NUM_CH-1:0]        ch_both_en,
  output logic [NUM_CH-1:0]        ch_low_pol,
  output logic [NUM_CH*FILT_W-1:0] ch_filt_sel
);
  // Register layout holds up to two select words of LANES_PER_REG lanes.
  localparam int SEL_W = LANE_W;

  logic [REG_W-1:0]        trig_q, padlo_q, padhi_q, filt_q;
  logic [NUM_PADS-1:0]     pads_sync;
  logic [NUM_CH*SEL_W-1:0] sel_flat;

  irq_pad_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .trig_q  (trig_q),
    .padlo_q (padlo_q),
    .padhi_q (padhi_q),
    .filt_q  (filt_q)
  );

  irq_pad_sync #(
    .WIDTH  (NUM_PADS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pads_sync)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int LANE = c % LANES_PER_REG;
    logic [SEL_W-1:0] sel_c;

    if (c < LANES_PER_REG) begin : g_lo
      assign sel_c = padlo_q[LANE*SEL_W +: SEL_W];
    end else begin : g_hi
      assign sel_c = padhi_q[LANE*SEL_W +: SEL_W];
    end

    assign sel_flat[c*SEL_W +: SEL_W] = sel_c;

    irq_chan_slice #(
      .NUM_PADS (NUM_PADS),
      .SEL_W    (SEL_W),
      .FILT_W   (FILT_W)
    ) u_slice (
      .clk     (clk),
      .rst     (rst),
      .pads    (pads_sync),
      .sel     (sel_c),
      .sgl_in  (trig_q[SGL_BASE + c]),
      .both_in (trig_q[BOTH_BASE + c]),
      .low_in  (trig_q[LOW_BASE + c]),
      .filt_in (filt_q[c*FILT_W +: FILT_W]),
      .raw_o   (ch_raw[c]),
      .sgl_o   (ch_sgl_en[c]),
      .both_o  (ch_both_en[c]),
      .low_o   (ch_low_pol[c]),
      .filt_o  (ch_filt_sel[c*FILT_W +: FILT_W])
    );
  end

  // Stored-only bits above the last polarity lane feed the read port alone.
  logic unused_trig_hi;
  assign unused_trig_hi = ^trig_q[REG_W-1:LOW_BASE+NUM_CH];
endmodule

// File: rtl/irq_pad_router_chk.sv
module irq_pad_router_chk
  import irq_pad_router_pkg::*;
#(
  parameter int NUM_PADS = 120,
  parameter int NUM_CH   = 8,
  parameter int SEL_W    = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     reg_we,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic [REG_W-1:0]         reg_wdata,
  input logic [REG_W-1:0]         reg_rdata,
  input logic [NUM_CH-1:0]        ch_raw,
  input logic [NUM_CH-1:0]        ch_sgl_en,
  input logic [NUM_CH-1:0]        ch_low_pol,
  input logic [NUM_CH*FILT_W-1:0] ch_filt_sel,
  input logic [REG_W-1:0]         trig_q,
  input logic [REG_W-1:0]         padlo_q,
  input logic [REG_W-1:0]         padhi_q,
  input logic [REG_W-1:0]         filt_q,
  input logic [NUM_CH*SEL_W-1:0]  sel_flat
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (reg_rdata == '0 && ch_raw == '0 && ch_filt_sel == '0));

  // R2
  filt_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == OFS_FILT) |=> (reg_rdata == $past(filt_q)));

  // R3
  hole_write_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && decode_addr(reg_addr) == RSEL_NONE) |=>
      ($stable(trig_q) && $stable(padlo_q) && $stable(padhi_q) && $stable(filt_q)));

  // R3
  hole_read_chk: assert property (@(posedge clk) disable iff (rst)
    (decode_addr(reg_addr) == RSEL_NONE) |=> (reg_rdata == '0));

  // R6
  sgl_map_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == OFS_TRIG) |-> ##2
      (ch_sgl_en == $past(reg_wdata[SGL_BASE +: NUM_CH], 2)));

  // R6
  low_map_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == OFS_TRIG) |-> ##2
      (ch_low_pol == $past(reg_wdata[LOW_BASE +: NUM_CH], 2)));

  // R7
  filt_map_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == OFS_FILT) |-> ##2
      (ch_filt_sel == $past(reg_wdata[NUM_CH*FILT_W-1:0], 2)));

  // R4
  lane0_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == OFS_PADLO) |=>
      (sel_flat[SEL_W-1:0] == $past(reg_wdata[SEL_W-1:0])));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_rng
    // R5
    out_of_range_zero_chk: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, sel_flat[c*SEL_W +: SEL_W]} >= (SEL_W+1)'(NUM_PADS)) |=> !ch_raw[c]);
  end
endmodule

bind irq_pad_router irq_pad_router_chk #(
  .NUM_PADS (NUM_PADS),
  .NUM_CH   (NUM_CH),
  .SEL_W    (SEL_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .ch_raw      (ch_raw),
  .ch_sgl_en   (ch_sgl_en),
  .ch_low_pol  (ch_low_pol),
  .ch_filt_sel (ch_filt_sel),
  .trig_q      (trig_q),
  .padlo_q     (padlo_q),
  .padhi_q     (padhi_q),
  .filt_q      (filt_q),
  .sel_flat    (sel_flat)
);

// File: tb/irq_pad_router_tb.sv
`timescale 1ns/1ps
module irq_pad_router_tb;
  localparam int NP = 120;
  localparam int NC = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NP-1:0]   pad_in = '0;
  logic [7:0]      reg_addr = '0;
  logic            reg_we = 1'b0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NC-1:0]   ch_raw, ch_sgl_en, ch_both_en, ch_low_pol;
  logic [NC*4-1:0] ch_filt_sel;

  int n_checks = 0;
  int n_fail   = 0;
  int sel_b [NC];

  always #10 clk = ~clk;

  irq_pad_router #(.NUM_PADS(NP), .NUM_CH(NC)) u_dut (
    .clk (clk), .rst (rst), .pad_in (pad_in),
    .reg_addr (reg_addr), .reg_we (reg_we), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata), .ch_raw (ch_raw), .ch_sgl_en (ch_sgl_en),
    .ch_both_en (ch_both_en), .ch_low_pol (ch_low_pol),
    .ch_filt_sel (ch_filt_sel)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [NC-1:0] route_exp();
    logic [NC-1:0] e;
    for (int c = 0; c < NC; c++) e[c] = (sel_b[c] < NP) ? pad_in[sel_b[c]] : 1'b0;
    return e;
  endfunction

  task automatic set_sel();
    wr(8'h04, {8'(sel_b[3]), 8'(sel_b[2]), 8'(sel_b[1]), 8'(sel_b[0])});
    wr(8'h08, {8'(sel_b[7]), 8'(sel_b[6]), 8'(sel_b[5]), 8'(sel_b[4])});
    step(1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1", "raw", 32'(ch_raw), 32'h0);
    check("R1", "sgl", 32'(ch_sgl_en), 32'h0);
    check("R1", "filt", ch_filt_sel, 32'h0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      rd(8'(i*4), v);
      check("R1", "reg zero", v, 32'h0);
    end
  endtask

  task automatic t_trigger();
    wr(8'h00, 32'h00A5_3C0F);
    // R9: outputs still old right after the write edge
    check("R9", "sgl before", 32'(ch_sgl_en), 32'h0);
    step(1);
    check("R6", "sgl", 32'(ch_sgl_en), 32'h0F);
    check("R6", "both", 32'(ch_both_en), 32'h3C);
    check("R6", "low", 32'(ch_low_pol), 32'hA5);
    wr(8'h00, 32'h005A_C3F0);
    step(1);
    check("R6", "sgl2", 32'(ch_sgl_en), 32'hF0);
    check("R6", "both2", 32'(ch_both_en), 32'hC3);
    check("R6", "low2", 32'(ch_low_pol), 32'h5A);
  endtask

  task automatic t_filter();
    wr(8'h0C, 32'h7E3F_19A2);
    check("R9", "filt before", ch_filt_sel, 32'h0);
    step(1);
    check("R7", "filt all", ch_filt_sel, 32'h7E3F_19A2);
    check("R7", "filt ch2", 32'(ch_filt_sel[8 +: 4]), 32'h9);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(8'h00, 32'hFF00_1234);
    wr(8'h04, 32'h89AB_CDEF);
    wr(8'h08, 32'h0102_0304);
    wr(8'h0C, 32'hFEDC_BA98);
    rd(8'h00, v); check("R2", "trig", v, 32'hFF00_1234);
    rd(8'h04, v); check("R2", "padlo", v, 32'h89AB_CDEF);
    rd(8'h08, v); check("R2", "padhi", v, 32'h0102_0304);
    rd(8'h0C, v); check("R2", "filt", v, 32'hFEDC_BA98);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h10, 32'hDEAD_BEEF);
    wr(8'h05, 32'h1234_5678);
    wr(8'hFC, 32'h0F0F_0F0F);
    step(1);
    check("R3", "filt port", ch_filt_sel, 32'hFEDC_BA98);
    check("R3", "low port", 32'(ch_low_pol), 32'h00);
    rd(8'h10, v); check("R3", "read 0x10", v, 32'h0);
    rd(8'h05, v); check("R3", "read 0x05", v, 32'h0);
    rd(8'h00, v); check("R3", "trig kept", v, 32'hFF00_1234);
    rd(8'h08, v); check("R3", "padhi kept", v, 32'h0102_0304);
  endtask

  task automatic t_route();
    sel_b = '{5, 17, 64, 119, 0, 100, 33, 77};
    set_sel();
    pad_in = '0;
    for (int c = 0; c < NC; c += 2) pad_in[sel_b[c]] = 1'b1;
    step(3);
    check("R4", "even pattern", 32'(ch_raw), 32'(route_exp()));
    pad_in = ~pad_in;
    step(3);
    check("R4", "odd pattern", 32'(ch_raw), 32'(route_exp()));
    pad_in = '0;
    pad_in[100] = 1'b1;
    step(3);
    check("R4", "ch5 only", 32'(ch_raw), 32'h20);
  endtask

  task automatic t_range();
    sel_b = '{120, 255, 119, 0, 200, 1, 121, 118};
    set_sel();
    pad_in = '1;
    step(3);
    check("R5", "range", 32'(ch_raw), 32'hAC);
    check("R5", "ch2 pad119", 32'(ch_raw[2]), 32'h1);
  endtask

  task automatic t_latency();
    sel_b = '{5, 6, 7, 8, 9, 10, 11, 12};
    set_sel();
    pad_in = '0;
    step(3);
    pad_in[5] = 1'b1;
    step(2);
    check("R8", "after 2 edges", 32'(ch_raw[0]), 32'h0);
    step(1);
    check("R8", "after 3 edges", 32'(ch_raw[0]), 32'h1);
    pad_in[5] = 1'b0;
    step(2);
    check("R8", "fall 2 edges", 32'(ch_raw[0]), 32'h1);
    step(1);
    check("R8", "fall 3 edges", 32'(ch_raw[0]), 32'h0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_trigger();
    t_filter();
    t_readback();
    t_unmapped();
    t_route();
    t_range();
    t_latency();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog run did not complete");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule